// File: doc/BRIEF.md
# Square-Wave Frequency Output Channel

This block is one output channel beside a free-running timer counter. It drives a square wave whose edges are placed by an 8-bit match value and an 8-bit step value. On every timer tick the low byte of the shared counter is compared with the match value. When the two are equal the output flips and the step is added to the match value. The 8-bit sum is allowed to wrap.

The spacing between output edges is therefore the step value in timer ticks. The output frequency is the tick rate divided by twice the step. A step of 3, for example, yields one sixth of the tick rate. Software sets up the channel over a small byte-wide register bus: it writes the step first and then the first match position. Reads return the register contents one cycle later. A one-cycle match pulse marks every edge.

Top module: `sqw_chan`

## Requirements
- R1: After synchronous reset the wave output is low, the match pulse is low, and both the match register and the step register read back as 0.
- R2: Only bits [7:0] of the counter input take part in the comparison. The upper counter bits have no effect on when a match occurs.
- R3: In a cycle where `tick` is high and the counter low byte equals the match register, the wave output flips on that clock edge. On the same edge the match register becomes (match + step) mod 256.
- R4: When `tick` is low, the wave output, the match pulse and the match register stay unchanged, even if the counter low byte equals the match register.
- R5: With step S in the range 1..255, consecutive wave edges are S ticks apart, so the output period is 2·S ticks. A step of 3 gives a period of 6 ticks.
- R6: A match sum that passes 255 wraps modulo 256. This does not change the edge spacing of S ticks.
- R7: A step of 0 acts as 256. The match register keeps its value, and edges are 256 ticks apart.
- R8: `match_pulse` is high for exactly the one cycle after each tick in which a match occurred, and it is low at all other times.
- R9: A bus write (`bus_we` high) at address 0 loads the match register, and a write at address 1 loads the step register. If a write to the match register lands in the same cycle as a match, the written value wins over the advance. A write to any other address changes nothing.
- R10: `bus_rdata` presents, one cycle after `bus_addr` is applied, the match register (address 0), the step register (address 1), or 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable; a match is acted on only when high |
| cnt | input | CNT_W (16) | Shared timer counter value |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Registered read data |
| wave | output | 1 | Square-wave output |
| match_pulse | output | 1 | One-cycle pulse per match |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter, 8-bit match and step registers, and a 2-bit address. The counter has upper bits above the compared byte, so the bench can run it with arbitrary upper bits set and cross byte boundaries. That brings R2 within reach. The 8-bit step width makes the full range of steps reachable in a short run. This covers a step of 1, a step of 0 taken as 256, and sums that wrap past 255. The edge spacing is measured in ticks for each of these steps, and for one of them ticks are held off on alternate cycles.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int unsigned ADDR_MATCH = 0;
  localparam int unsigned ADDR_STEP  = 1;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_MATCH = 2'd1,
    SEL_STEP  = 2'd2
  } sqw_sel_e;
endpackage

// File: rtl/sqw_regs.sv
module sqw_regs
  import sqw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              advance,
  output logic [DATA_W-1:0] match_q,
  output logic [DATA_W-1:0] step_q,
  output logic [DATA_W-1:0] rdata_q
);
  sqw_sel_e sel;

  always_comb begin
    if (addr == ADDR_W'(ADDR_MATCH))      sel = SEL_MATCH;
    else if (addr == ADDR_W'(ADDR_STEP))  sel = SEL_STEP;
    else                                  sel = SEL_NONE;
  end

  // a bus write to the match register takes precedence over the advance
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
    end else if (we && sel == SEL_MATCH) begin
      match_q <= wdata;
    end else if (advance) begin
      match_q <= match_q + step_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
    end else if (we && sel == SEL_STEP) begin
      step_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (sel)
        SEL_MATCH: rdata_q <= match_q;
        SEL_STEP:  rdata_q <= step_q;
        default:   rdata_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sqw_cmp.sv
module sqw_cmp #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] match_v,
  output logic              hit
);
  logic [DATA_W-1:0] cnt_low;

  assign cnt_low = cnt[DATA_W-1:0];
  assign hit     = tick && (cnt_low == match_v);
endmodule

// File: rtl/sqw_out.sv
module sqw_out (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic wave_q,
  output logic pulse_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (hit) wave_q <= ~wave_q;
    end
  end
endmodule

// File: rtl/sqw_chan.sv
module sqw_chan #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wave,
  output logic              match_pulse
);
  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] step_q;
  logic              hit;

  sqw_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .advance (hit),
    .match_q (match_q),
    .step_q  (step_q),
    .rdata_q (bus_rdata)
  );

  sqw_cmp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
    .tick    (tick),
    .cnt     (cnt),
    .match_v (match_q),
    .hit     (hit)
  );

  sqw_out u_out (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .wave_q  (wave),
    .pulse_q (match_pulse)
  );
endmodule

// File: rtl/sqw_chk.sv
module sqw_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wave,
  input logic              match_pulse,
  input logic [DATA_W-1:0] match_v,
  input logic [DATA_W-1:0] step_v
);
  logic eq_low;
  logic wr_match;
  assign eq_low   = (cnt[DATA_W-1:0] == match_v);
  assign wr_match = bus_we && (bus_addr == ADDR_W'(sqw_pkg::ADDR_MATCH));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!wave && !match_pulse && match_v == '0 && step_v == '0));

  // R3
  toggle_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && eq_low) |=> (wave != $past(wave)));

  // R6
  match_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && eq_low && !wr_match) |=>
      (match_v == DATA_W'($past(match_v) + $past(step_v))));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick && eq_low) |=> ($stable(wave) && !match_pulse));

  // R8
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(tick));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_match |=> (match_v == $past(bus_wdata)));
endmodule

bind sqw_chan sqw_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .cnt         (cnt),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .wave        (wave),
  .match_pulse (match_pulse),
  .match_v     (match_q),
  .step_v      (step_q)
);

// File: tb/test_sqw_chan.sv
module test_sqw_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] cnt = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        wave;
  logic        match_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sqw_chan i_sqw_chan (
    .clk(clk), .rst(rst), .tick(tick), .cnt(cnt),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wave(wave), .match_pulse(match_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = 2'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  // measure edge spacing in ticks for one step value
  task automatic run_freq(input int step, input int start, input int ntog,
                          input bit gappy, input string req);
    int c, prev_c, last_c, toggles, cyc, v, exp_gap;
    bit prev_tick, prev_out, tg;
    exp_gap = (step == 0) ? 256 : step;
    wr(1, step);
    wr(0, start);
    c = 16'h1200 + ((start - 5) & 255);
    prev_c = c; last_c = 0; toggles = 0; cyc = 0;
    prev_tick = 1'b0; prev_out = wave;
    while (toggles < ntog && cyc < 4000) begin
      @(negedge clk);
      if (prev_tick) begin
        tg = (wave != prev_out);
        chk(match_pulse == tg, "R8", int'(match_pulse), int'(tg));
        if (tg) begin
          if (toggles == 0)
            chk((prev_c & 255) == start, "R3", prev_c & 255, start);
          else
            chk(prev_c - last_c == exp_gap, req, prev_c - last_c, exp_gap);
          last_c = prev_c;
          toggles++;
        end
        prev_out = wave;
      end else if (gappy && cyc > 0) begin
        chk(wave == prev_out && !match_pulse, "R4", int'(wave), int'(prev_out));
      end
      if (toggles >= ntog) break;
      tick = gappy ? (cyc % 2 == 0) : 1'b1;
      cnt = 16'(c);
      prev_tick = tick;
      prev_c = c;
      if (tick) c++;
      cyc++;
    end
    tick = 1'b0;
    chk(toggles == ntog, req, toggles, ntog);
    rd(0, v);
    chk(v == ((start + ntog * step) & 255), "R6", v, (start + ntog * step) & 255);
  endtask

  task automatic t_reset;
    int v;
    @(negedge clk);
    chk(wave == 1'b0, "R1", int'(wave), 0);
    chk(match_pulse == 1'b0, "R1", int'(match_pulse), 0);
    rd(0, v); chk(v == 0, "R1", v, 0);
    rd(1, v); chk(v == 0, "R1", v, 0);
  endtask

  task automatic t_upper_bits;
    int v;
    bit w0;
    wr(1, 5);
    wr(0, 8'h3c);
    @(negedge clk);
    w0 = wave;
    tick = 1'b1; cnt = 16'hab3c;
    @(negedge clk);
    tick = 1'b0;
    chk(wave != w0, "R2", int'(wave), int'(!w0));
    rd(0, v); chk(v == 8'h41, "R3", v, 8'h41);
  endtask

  task automatic t_idle_and_bus;
    int v;
    bit w0;
    wr(1, 9);
    wr(0, 8'h20);
    @(negedge clk);
    w0 = wave;
    tick = 1'b0; cnt = 16'h0020;
    repeat (4) @(negedge clk);
    chk(wave == w0 && !match_pulse, "R4", int'(wave), int'(w0));
    rd(0, v); chk(v == 8'h20, "R4", v, 8'h20);
    // write lands in the same cycle as a match
    @(negedge clk);
    tick = 1'b1; cnt = 16'h0520;
    bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h40;
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0;
    chk(wave != w0, "R3", int'(wave), int'(!w0));
    rd(0, v); chk(v == 8'h40, "R9", v, 8'h40);
    wr(2, 8'h77);
    wr(3, 8'h66);
    rd(0, v); chk(v == 8'h40, "R9", v, 8'h40);
    rd(1, v); chk(v == 9, "R9", v, 9);
    rd(2, v); chk(v == 0, "R10", v, 0);
    rd(1, v); chk(v == 9, "R10", v, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_upper_bits();
    t_idle_and_bus();
    run_freq(3, 10, 6, 1'b0, "R5");
    run_freq(1, 0, 5, 1'b0, "R5");
    run_freq(7, 250, 6, 1'b1, "R6");
    run_freq(200, 100, 4, 1'b0, "R6");
    run_freq(0, 8'h80, 3, 1'b0, "R7");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule